// File: doc/BRIEF.md
# Command Ring Buffer Engine

This block keeps a circular queue of 32-bit commands in an internal RAM and sends them one by one to a codec link. Software writes command words straight into the ring RAM through a word-addressed write port. It then moves the write pointer forward to the index of the last command it placed. While the run bit is set, the engine pre-increments its read pointer and reads that entry. It presents the entry on a valid/ready output and waits for the link to take it before it fetches the next one.

The ring can hold 2, 16 or 256 entries. A fixed capability parameter says which of these sizes the instance supports. Software picks one through a select field while the engine is stopped. Pointer arithmetic wraps at the selected size. Because a write pointer equal to the read pointer means "empty", software can have at most N-1 commands outstanding: one slot always stays unused.

Top module: `cmd_ring_engine`

## Requirements
- R1: After reset, register 0 reads the capability parameter in bits [6:4] and the select code in bits [1:0]. The select code resets to the largest supported size (code 2 if capability bit 2 is set, else code 1 if bit 1 is set, else code 0). Register 1 (read pointer), register 2 (write pointer) and register 3 (control) read zero, and cmd_valid_o is low.
- R2: Select codes 0, 1 and 2 give rings of 2, 16 and 256 entries. A write of code 3, or of a code whose capability bit is clear, leaves the select unchanged. An accepted select write returns both pointers to zero.
- R3: A write to the select field while the run bit is set has no effect.
- R4: Register 1 shows the read pointer in bits [7:0], and software cannot write it directly. Writing register 1 with bit 15 set forces the read pointer to zero. Other bits of that write are ignored.
- R5: Register 2 holds the write pointer in bits [7:0]. A written value is stored modulo the selected size N.
- R6: Register 3 bit 0 is the run bit. While it is clear, no entry is fetched and the read pointer does not move, even when the pointers differ.
- R7: While running with read pointer rp different from the write pointer, the engine sets rp to (rp+1) mod N and presents the RAM word at that index on cmd_data_o. Entries go out in ring order.
- R8: While cmd_valid_o is high and cmd_ready_i is low, cmd_valid_o stays high and cmd_data_o stays stable. Each entry is sent exactly once.
- R9: Equal pointers mean an empty ring, and nothing is sent. After N-1 entries are written starting from equal pointers, the ring is full: exactly N-1 transfers follow and the read pointer ends equal to the write pointer.
- R10: The read pointer wraps from N-1 to 0 for each selected size, and it never holds a value of N or more.
- R11: A ring RAM write stores ram_wdata_i at index ram_addr_i, and that word is what the engine later sends for that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | Register write strobe |
| csr_addr_i | input | 2 | Register index (0 size, 1 read ptr, 2 write ptr, 3 control) |
| csr_wdata_i | input | 16 | Register write data |
| csr_rdata_o | output | 16 | Read data of the register at csr_addr_i |
| ram_we_i | input | 1 | Ring RAM write strobe |
| ram_addr_i | input | 8 | Ring RAM word index |
| ram_wdata_i | input | 32 | Ring RAM write data |
| cmd_valid_o | output | 1 | Command presented to the link |
| cmd_data_o | output | 32 | Command word |
| cmd_ready_i | input | 1 | Link accepts the command |

## Verification
The main instance is built with all three capability bits set, so every ring size can be selected. The vector loop runs 2, 16 and 256 entry rings, each filled to the full condition and each wrapped across index zero, with and without link back-pressure. A second instance advertises only the 16-entry size. Against that instance the bench checks the reset choice of select code and the rejection of select codes the capability does not allow.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;
  localparam int RING_MAX = 256;
  localparam int PTR_W    = $clog2(RING_MAX);
  localparam int CSR_W    = 16;
  localparam int CAP_LSB  = 4;
  localparam int RP_CLR_BIT = 15;

  typedef enum logic [1:0] {
    REG_SIZE  = 2'd0,
    REG_RDPTR = 2'd1,
    REG_WRPTR = 2'd2,
    REG_CTRL  = 2'd3
  } ring_reg_e;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_FETCH = 2'd1,
    FS_SEND  = 2'd2
  } fetch_state_e;

  function automatic logic [PTR_W-1:0] ring_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    ring_mask = PTR_W'(1);
      2'd1:    ring_mask = PTR_W'(15);
      default: ring_mask = PTR_W'(RING_MAX - 1);
    endcase
  endfunction
endpackage

// File: rtl/cmd_ring_regs.sv
module cmd_ring_regs
  import cmd_ring_pkg::*;
#(
  parameter logic [2:0] SIZE_CAP = 3'b111
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csr_we_i,
  input  logic [1:0]       csr_addr_i,
  input  logic [CSR_W-1:0] csr_wdata_i,
  output logic [CSR_W-1:0] csr_rdata_o,
  input  logic [PTR_W-1:0] rp_i,
  output logic [PTR_W-1:0] wp_o,
  output logic [PTR_W-1:0] mask_o,
  output logic             run_o,
  output logic             rp_clr_o
);
  localparam logic [1:0] SEL_RST = SIZE_CAP[2] ? 2'd2 : (SIZE_CAP[1] ? 2'd1 : 2'd0);
  localparam logic [3:0] CAP_EXT = {1'b0, SIZE_CAP};

  logic [1:0]       sel_q;
  logic [PTR_W-1:0] wp_q;
  logic             run_q;
  logic             sel_ok;
  logic             sel_wr;

  assign sel_ok = (csr_wdata_i[1:0] != 2'd3) && CAP_EXT[csr_wdata_i[1:0]];
  assign sel_wr = csr_we_i && (csr_addr_i == REG_SIZE) && !run_q && sel_ok;
  assign mask_o = ring_mask(sel_q);
  assign wp_o   = wp_q;
  assign run_o  = run_q;
  assign rp_clr_o = sel_wr ||
                    (csr_we_i && (csr_addr_i == REG_RDPTR) && csr_wdata_i[RP_CLR_BIT]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= SEL_RST;
      wp_q  <= '0;
      run_q <= 1'b0;
    end else begin
      if (sel_wr) begin
        sel_q <= csr_wdata_i[1:0];
        wp_q  <= '0;
      end else if (csr_we_i && csr_addr_i == REG_WRPTR) begin
        wp_q <= csr_wdata_i[PTR_W-1:0] & mask_o;
      end
      if (csr_we_i && csr_addr_i == REG_CTRL) run_q <= csr_wdata_i[0];
    end
  end

  always_comb begin
    csr_rdata_o = '0;
    case (csr_addr_i)
      REG_SIZE: begin
        csr_rdata_o[CAP_LSB +: 3] = SIZE_CAP;
        csr_rdata_o[1:0]          = sel_q;
      end
      REG_RDPTR: csr_rdata_o[PTR_W-1:0] = rp_i;
      REG_WRPTR: csr_rdata_o[PTR_W-1:0] = wp_q;
      default:   csr_rdata_o[0] = run_q;
    endcase
  end

  a_r3_sel_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_addr_i == REG_SIZE && run_q) |=> $stable(sel_q));
  a_r2_sel_supported: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SIZE_CAP != 3'b000) |-> (sel_q != 2'd3 && CAP_EXT[sel_q]));
  a_r5_wp_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_q & ~mask_o) == '0);
endmodule

// File: rtl/cmd_ring_ram.sv
module cmd_ring_ram #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
  import cmd_ring_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [PTR_W-1:0]  wp_i,
  input  logic [PTR_W-1:0]  mask_i,
  input  logic              rp_clr_i,
  output logic [PTR_W-1:0]  rp_o,
  output logic              rd_en_o,
  output logic [PTR_W-1:0]  rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              cmd_valid_o,
  output logic [DATA_W-1:0] cmd_data_o,
  input  logic              cmd_ready_i
);
  fetch_state_e      state_q;
  logic [PTR_W-1:0]  rp_q;
  logic [PTR_W-1:0]  rp_inc;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  assign rp_inc    = (rp_q + PTR_W'(1)) & mask_i;
  assign rd_en_o   = (state_q == FS_IDLE) && run_i && !rp_clr_i && (rp_q != wp_i);
  assign rd_addr_o = rp_inc;
  assign rp_o      = rp_q;
  assign cmd_valid_o = valid_q;
  assign cmd_data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_IDLE;
      rp_q    <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      case (state_q)
        FS_IDLE: if (rd_en_o) begin
          rp_q    <= rp_inc;
          state_q <= FS_FETCH;
        end
        FS_FETCH: begin
          data_q  <= rd_data_i;
          valid_q <= 1'b1;
          state_q <= FS_SEND;
        end
        default: if (cmd_ready_i) begin
          valid_q <= 1'b0;
          state_q <= FS_IDLE;
        end
      endcase
      if (rp_clr_i) rp_q <= '0;
    end
  end

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_data_o)));
  a_r6_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !rp_clr_i && state_q == FS_IDLE) |=> $stable(rp_q));
  a_r10_rp_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rp_q & ~mask_i) == '0);
  a_r9_empty_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == FS_IDLE && rp_q == wp_i) |=> !cmd_valid_o);
endmodule

// File: rtl/cmd_ring_engine.sv
module cmd_ring_engine
  import cmd_ring_pkg::*;
#(
  parameter logic [2:0] SIZE_CAP = 3'b111,
  parameter int         DATA_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_we_i,
  input  logic [1:0]        csr_addr_i,
  input  logic [CSR_W-1:0]  csr_wdata_i,
  output logic [CSR_W-1:0]  csr_rdata_o,
  input  logic              ram_we_i,
  input  logic [PTR_W-1:0]  ram_addr_i,
  input  logic [DATA_W-1:0] ram_wdata_i,
  output logic              cmd_valid_o,
  output logic [DATA_W-1:0] cmd_data_o,
  input  logic              cmd_ready_i
);
  logic [PTR_W-1:0]  rp, wp, mask, rd_addr;
  logic              run, rp_clr, rd_en;
  logic [DATA_W-1:0] rd_data;

  cmd_ring_regs #(.SIZE_CAP(SIZE_CAP)) u_regs (
    .clk_i, .rst_ni, .csr_we_i, .csr_addr_i, .csr_wdata_i, .csr_rdata_o,
    .rp_i(rp), .wp_o(wp), .mask_o(mask), .run_o(run), .rp_clr_o(rp_clr)
  );

  cmd_ring_ram #(.DEPTH(RING_MAX), .DATA_W(DATA_W)) u_ram (
    .clk_i, .we_i(ram_we_i), .waddr_i(ram_addr_i), .wdata_i(ram_wdata_i),
    .re_i(rd_en), .raddr_i(rd_addr), .rdata_o(rd_data)
  );

  cmd_ring_fetch #(.DATA_W(DATA_W)) u_fetch (
    .clk_i, .rst_ni, .run_i(run), .wp_i(wp), .mask_i(mask), .rp_clr_i(rp_clr),
    .rp_o(rp), .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .cmd_valid_o, .cmd_data_o, .cmd_ready_i
  );
endmodule

// File: tb/cmd_ring_engine_test.sv
module cmd_ring_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csr_we = 1'b0;
  logic [1:0] csr_addr = '0;
  logic [15:0] csr_wdata = '0;
  logic [15:0] rdata, rdata_cap;
  logic ram_we = 1'b0;
  logic [7:0] ram_addr = '0;
  logic [31:0] ram_wdata = '0;
  logic cmd_valid, cmd_valid_cap;
  logic [31:0] cmd_data, cmd_data_cap;
  logic cmd_ready = 1'b1;

  always #2.5 clk = ~clk;

  cmd_ring_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(csr_we), .csr_addr_i(csr_addr),
    .csr_wdata_i(csr_wdata), .csr_rdata_o(rdata), .ram_we_i(ram_we),
    .ram_addr_i(ram_addr), .ram_wdata_i(ram_wdata), .cmd_valid_o(cmd_valid),
    .cmd_data_o(cmd_data), .cmd_ready_i(cmd_ready)
  );

  cmd_ring_engine #(.SIZE_CAP(3'b010)) uut_cap (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(csr_we), .csr_addr_i(csr_addr),
    .csr_wdata_i(csr_wdata), .csr_rdata_o(rdata_cap), .ram_we_i(ram_we),
    .ram_addr_i(ram_addr), .ram_wdata_i(ram_wdata), .cmd_valid_o(cmd_valid_cap),
    .cmd_data_o(cmd_data_cap), .cmd_ready_i(1'b1)
  );

  int n_run = 0, n_fail = 0;
  int rx_cnt = 0;
  logic [31:0] rx_data [300];
  logic [31:0] exp_data [300];
  int cyc = 0;
  bit stall = 0, hold_low = 0, done = 0;

  // vector: [15:14] select, [11] stall, [10] keep pointers, [8:0] count
  localparam logic [15:0] VEC [8] = '{
    {2'd0, 2'b0, 1'b0, 1'b0, 1'b0, 9'd1},
    {2'd0, 2'b0, 1'b0, 1'b1, 1'b0, 9'd1},
    {2'd1, 2'b0, 1'b0, 1'b0, 1'b0, 9'd15},
    {2'd1, 2'b0, 1'b0, 1'b1, 1'b0, 9'd7},
    {2'd1, 2'b0, 1'b1, 1'b1, 1'b0, 9'd15},
    {2'd2, 2'b0, 1'b0, 1'b0, 1'b0, 9'd255},
    {2'd2, 2'b0, 1'b1, 1'b1, 1'b0, 9'd10},
    {2'd2, 2'b0, 1'b1, 1'b0, 1'b0, 9'd3}
  };

  always @(negedge clk) begin
    cyc <= cyc + 1;
    cmd_ready <= hold_low ? 1'b0 : (stall ? ((cyc % 3) != 0) : 1'b1);
  end

  always @(posedge clk)
    if (rst_n && cmd_valid && cmd_ready && rx_cnt < 300) begin
      rx_data[rx_cnt] = cmd_data;
      rx_cnt = rx_cnt + 1;
    end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_rd(input logic [1:0] a, output logic [15:0] d, output logic [15:0] dc);
    @(negedge clk);
    csr_addr = a;
    #1;
    d = rdata; dc = rdata_cap;
  endtask

  task automatic ram_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    ram_we = 1'b1; ram_addr = a; ram_wdata = d;
    @(negedge clk);
    ram_we = 1'b0;
  endtask

  initial begin
    logic [15:0] d, dc;
    logic [7:0] ptr, mask;
    logic [31:0] held;
    int errs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    csr_rd(2'd0, d, dc);
    check(d == 16'h0072, "R1 size reg reset", d, 16'h0072);
    check(dc == 16'h0021, "R1 size reg reset, 16-only capability", dc, 16'h0021);
    csr_rd(2'd1, d, dc);
    check(d == 0, "R1 rp reset", d, 0);
    csr_rd(2'd2, d, dc);
    check(d == 0, "R1 wp reset", d, 0);
    csr_rd(2'd3, d, dc);
    check(d == 0 && !cmd_valid, "R1 run/valid reset", {d[0], cmd_valid}, 0);

    // R2: unsupported codes ignored
    csr_wr(2'd0, 16'h0003);
    csr_rd(2'd0, d, dc);
    check(d[1:0] == 2'd2, "R2 code 3 ignored", d[1:0], 2'd2);
    csr_wr(2'd0, 16'h0002);
    csr_rd(2'd0, d, dc);
    check(dc[1:0] == 2'd1, "R2 code 2 ignored without capability", dc[1:0], 2'd1);
    csr_wr(2'd0, 16'h0000);
    csr_rd(2'd0, d, dc);
    check(dc[1:0] == 2'd1, "R2 code 0 ignored without capability", dc[1:0], 2'd1);
    check(d[1:0] == 2'd0, "R2 code 0 accepted", d[1:0], 2'd0);

    // R3: select locked while running
    csr_wr(2'd3, 16'h0001);
    csr_wr(2'd0, 16'h0002);
    csr_rd(2'd0, d, dc);
    check(d[1:0] == 2'd0, "R3 select write ignored while running", d[1:0], 2'd0);
    csr_wr(2'd3, 16'h0000);

    // vector loop: R7 R9 R10 R11
    ptr = 0;
    for (int v = 0; v < 8; v++) begin
      int cnt;
      cnt = int'(VEC[v][8:0]);
      mask = (VEC[v][15:14] == 2'd0) ? 8'd1 : (VEC[v][15:14] == 2'd1) ? 8'd15 : 8'd255;
      csr_wr(2'd3, 16'h0000);
      if (!VEC[v][10]) begin
        csr_wr(2'd0, {14'd0, VEC[v][15:14]});
        csr_wr(2'd1, 16'h8000);
        csr_wr(2'd2, 16'h0000);
        ptr = 0;
      end
      for (int i = 0; i < cnt; i++) begin
        ptr = (ptr + 8'd1) & mask;
        exp_data[i] = {v[7:0], 8'h5A, i[7:0], ptr};
        ram_wr(ptr, exp_data[i]);
      end
      rx_cnt = 0;
      stall = VEC[v][11];
      csr_wr(2'd2, {8'd0, ptr});
      csr_wr(2'd3, 16'h0001);
      for (int w = 0; w < cnt * 8 + 50 && rx_cnt < cnt; w++) @(negedge clk);
      repeat (12) @(negedge clk);
      check(rx_cnt == cnt, "R9 transfer count equals entries written", rx_cnt, cnt);
      errs = 0;
      for (int i = 0; i < cnt; i++) if (rx_data[i] !== exp_data[i]) errs++;
      check(errs == 0, "R7/R11 command order and data", errs, 0);
      csr_rd(2'd1, d, dc);
      check(d[7:0] == ptr, "R10 rp wrapped to wp", d[7:0], ptr);
      stall = 0;
    end

    // R4: rp not writable, reset bit clears
    csr_wr(2'd3, 16'h0000);
    csr_wr(2'd1, 16'h0005);
    csr_rd(2'd1, d, dc);
    check(d[7:0] == ptr, "R4 rp direct write ignored", d[7:0], ptr);
    csr_wr(2'd1, 16'h8000);
    csr_rd(2'd1, d, dc);
    check(d == 0, "R4 rp reset bit clears", d, 0);

    // R5: wp masked to size
    csr_wr(2'd0, 16'h0001);
    csr_wr(2'd2, 16'h00FF);
    csr_rd(2'd2, d, dc);
    check(d == 16'h000F, "R5 wp masked to 16 entries", d, 16'h000F);

    // R2: accepted select clears pointers
    csr_wr(2'd0, 16'h0001);
    csr_rd(2'd2, d, dc);
    check(d == 0, "R2 select write clears wp", d, 0);

    // R6: stopped engine fetches nothing
    rx_cnt = 0;
    ram_wr(8'd1, 32'hCAFE0001);
    ram_wr(8'd2, 32'hCAFE0002);
    csr_wr(2'd2, 16'h0002);
    repeat (30) @(negedge clk);
    csr_rd(2'd1, d, dc);
    check(rx_cnt == 0 && !cmd_valid && d == 0, "R6 no fetch while stopped", {rx_cnt[15:0], d}, 0);

    // R8: hold under back-pressure
    hold_low = 1;
    csr_wr(2'd3, 16'h0001);
    repeat (20) @(negedge clk);
    held = cmd_data;
    check(cmd_valid && held == 32'hCAFE0001, "R8 first entry presented", held, 32'hCAFE0001);
    repeat (10) @(negedge clk);
    csr_rd(2'd1, d, dc);
    check(cmd_valid && cmd_data == held && d == 1, "R8 entry held, rp still 1",
          {d[7:0], cmd_data[23:0]}, {8'd1, held[23:0]});
    hold_low = 0;
    repeat (20) @(negedge clk);
    check(rx_cnt == 2 && rx_data[0] == 32'hCAFE0001 && rx_data[1] == 32'hCAFE0002,
          "R8 each entry sent once in order", rx_cnt, 2);

    // R9: empty ring idles
    repeat (10) @(negedge clk);
    check(!cmd_valid && rx_cnt == 2, "R9 empty ring sends nothing", {cmd_valid, rx_cnt[15:0]}, 2);

    done = 1;
    summary();
  end
endmodule